// File: doc/BRIEF.md
# Two-Address I2C Slave with Paged Nonvolatile Commit

This block is the serial front end of a small register store that a host reaches over a two-wire I2C bus. It answers at two 7-bit device addresses. One reaches an auxiliary bank and the other reaches a main bank, and each bank holds 256 bytes. A write carries a one-byte register pointer and then any number of data bytes. A read sets the pointer with a short write, then issues a repeated START in the read direction and clocks out bytes in sequence.

Written bytes collect in an 8-byte page buffer. The STOP that ends a write opens a busy window of a fixed number of system clocks. At the end of that window the bytes that were written replace their old values in the page, and all other bytes in the page keep their values. For the whole window the slave refuses its own address. A host can therefore poll with bare address probes until it gets an ACK, and then continue. The main bank's address can be taken from a configuration input at run time. If that address equals the auxiliary address, the main bank takes it.

Top module: `i2c_paged_nvm_slave`

## Requirements
- R1: With `addr_sel`=0, the slave ACKs the address byte A0h/A1h for the auxiliary bank and A2h/A3h for the main bank, and NACKs every other address. ACK means the slave pulls SDA low (`sda_oe`=1) while SCL is high in the ninth clock.
- R2: With `addr_sel`=1, the main bank answers at `main_cfg[7:1]` and no longer at A2h. The auxiliary bank still answers at A0h, except when `main_cfg[7:1]` equals 50h (byte A0h), in which case A0h reaches the main bank.
- R3: A write consists of the address byte with bit 0 = 0, one pointer byte, and then data bytes. The slave ACKs every one of these bytes.
- R4: After a repeated START with bit 0 = 1, the slave sends the byte at the pointer, MSB first. Each master ACK advances the pointer by one and fetches the next byte. A master NACK ends the transfer.
- R5: Each written data byte goes to the pointer location. The pointer's low three bits then advance modulo 8 while its upper bits stay the same, so a burst wraps inside its 8-byte page.
- R6: After the busy window that follows the STOP, the written bytes hold their new values and the unwritten bytes of the same page hold their previous values.
- R7: For WRITE_CYCLES clocks after a STOP that ends a write with at least one data byte, the slave NACKs both of its addresses. After the window it ACKs them again.
- R8: A STOP that comes before any data byte, and the end of a read transaction, do not start a busy window. An address probe right afterwards is ACKed.
- R9: After reset the slave releases SDA and waits for a START.
- R10: The two banks are separate storage. A write through one address leaves the same pointer location in the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level as seen on the wire (asynchronous) |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| addr_sel | input | 1 | 0: fixed main address A2h; 1: main address from `main_cfg` |
| main_cfg | input | 8 | Programmed main address in 8-bit byte form; bit 0 ignored |

## Verification
Two functions can meet in the same clock. One is the end of the busy window, which writes the page into storage and frees the slave. The other is the ACK decision for an address probe, which is taken on the falling SCL edge after the eighth bit. The bench provokes this by sending back-to-back probes right after every write burst, so a probe keeps landing at different offsets around the window's end. It judges the outcome on two points. First, the probe issued immediately after the STOP must be refused. Second, once a probe is accepted, a read of the whole page must already return the new bytes beside the preserved old ones, as the bench's model of wrapped writes predicts.

// File: rtl/i2c_nvm_pkg.sv
// Shared constants and state encoding for the paged I2C slave.
package i2c_nvm_pkg;

    // 7-bit device identities used when no programmed address applies
    localparam logic [6:0] AUX_DEV       = 7'h50;
    localparam logic [6:0] MAIN_DEV_DFLT = 7'h51;

    // Number of bytes in one nonvolatile page (pointer bits [2:0])
    localparam int PAGE_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE,    // ignoring the bus until START
        ST_ADDR,    // shifting in the address byte
        ST_AACK,    // driving ACK for the address
        ST_REG,     // shifting in the pointer byte
        ST_REGACK,  // driving ACK for the pointer
        ST_WDATA,   // shifting in a data byte
        ST_WACK,    // driving ACK for a data byte
        ST_TXLD,    // fetching the next byte to send
        ST_TX,      // shifting a byte out
        ST_MACK     // sampling the master's ACK/NACK
    } slv_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
// i2c_bus_sync: brings SCL and SDA into the clock domain through two flops
// each, then derives SCL edges and START/STOP events (SDA edges while SCL is
// high). Assumes the bus is at least several system clocks per SCL phase.
module i2c_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lv,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    // Two-stage synchronizer plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign sda_lv    = sda_ff[1];
    assign scl_rise  = scl_ff[1] & ~scl_q;
    assign scl_fall  = ~scl_ff[1] & scl_q;
    assign start_det = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
    assign stop_det  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];

endmodule

// File: rtl/i2c_slave_fsm.sv
// i2c_slave_fsm: bit-level protocol engine. Decodes the address byte for the
// two banks, keeps the register pointer, issues write strobes with in-page
// wrap, serves sequential reads, and requests a page commit at STOP when data
// was written. Assumes synchronized SCL edges and START/STOP events.
module i2c_slave_fsm
    import i2c_nvm_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_lv,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             busy_i,
    input  logic             addr_sel,
    input  logic [7:0]       main_cfg,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             mem_sel,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_stb,
    output logic [7:0]       wr_data,
    output logic             page_set,
    output logic [7:0]       page_byte,
    output logic             commit_req
);
    slv_state_t st;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txb;
    logic       rw;
    logic       wrote;
    logic       mack;

    logic [6:0] main_dev;
    logic       main_hit, aux_hit, byte_done, ev_ok;

    // Address decode: programmed main address wins a clash with the aux one
    always_comb begin
        main_dev  = addr_sel ? main_cfg[7:1] : MAIN_DEV_DFLT;
        main_hit  = (shreg[7:1] == main_dev);
        aux_hit   = (shreg[7:1] == AUX_DEV) && (main_dev != AUX_DEV);
        byte_done = scl_fall && (bitcnt == 4'd8);
        ev_ok     = !start_det && !stop_det;
    end

    assign wr_stb     = ev_ok && (st == ST_WDATA) && byte_done;
    assign wr_data    = shreg;
    assign page_set   = ev_ok && (st == ST_REG) && byte_done;
    assign page_byte  = shreg;
    assign commit_req = stop_det && wrote;

    // Protocol state machine; START and STOP override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txb     <= '0;
            rw      <= 1'b0;
            wrote   <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            mem_sel <= 1'b0;
            ptr     <= '0;
        end else if (start_det) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lv};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_ADDR) begin
                            if ((main_hit || aux_hit) && !busy_i) begin
                                sda_oe  <= 1'b1;
                                rw      <= shreg[0];
                                mem_sel <= main_hit;
                                st      <= ST_AACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_REG) begin
                            sda_oe <= 1'b1;
                            ptr    <= shreg[PTR_W-1:0];
                            st     <= ST_REGACK;
                        end else begin
                            sda_oe <= 1'b1;
                            ptr    <= {ptr[PTR_W-1:3], ptr[2:0] + 3'd1};
                            wrote  <= 1'b1;
                            st     <= ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= rw ? ST_TXLD : ST_REG;
                    end
                end
                ST_REGACK, ST_WACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_WDATA;
                    end
                end
                ST_TXLD: begin
                    txb    <= rd_data;
                    sda_oe <= ~rd_data[7];
                    bitcnt <= '0;
                    st     <= ST_TX;
                end
                ST_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st     <= ST_MACK;
                        end else begin
                            sda_oe <= ~txb[6];
                            txb    <= {txb[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack <= ~sda_lv;
                    if (scl_fall) begin
                        if (mack) begin
                            ptr <= ptr + {{(PTR_W-1){1'b0}}, 1'b1};
                            st  <= ST_TXLD;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: an address ACK is never being driven while a commit window runs
    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK) |-> !busy_i);

    // R5: a data write never moves the pointer out of its page
    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ptr[PTR_W-1:3] == $past(ptr[PTR_W-1:3])));

    // R9: the data line is released whenever the engine is idle
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/nvm_page_store.sv
// nvm_page_store: two banks of byte storage behind an 8-byte page buffer
// with a per-byte written mask. A commit request starts a countdown of
// WRITE_CYCLES clocks; on its last clock only the masked bytes are written,
// so the rest of the page keeps its contents. Assumes no new page is opened
// while busy (the protocol engine NACKs during the window).
module nvm_page_store #(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_set,
    input  logic              set_sel,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit_req,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PG_W   = ADDR_W - 3;
    localparam int CELLS  = 2 ** (ADDR_W + 1);
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

    logic [7:0]       cells [CELLS];
    logic [7:0]       pbuf  [8];
    logic [7:0]       pmask;
    logic             psel;
    logic [PG_W-1:0]  ppage;
    logic [CNT_W-1:0] busy_cnt;
    logic             commit_now;

    assign busy       = (busy_cnt != '0);
    assign commit_now = (busy_cnt == CNT_W'(1));
    assign rd_data    = cells[{rd_sel, rd_addr}];

    // Page buffer, written mask and commit countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask    <= '0;
            psel     <= 1'b0;
            ppage    <= '0;
            busy_cnt <= '0;
        end else begin
            if (page_set && !busy) begin
                psel  <= set_sel;
                ppage <= set_addr[ADDR_W-1:3];
                pmask <= '0;
            end
            if (wr_stb) begin
                pbuf[wr_addr[2:0]]  <= wr_data;
                pmask[wr_addr[2:0]] <= 1'b1;
            end
            if (commit_req && !busy) begin
                busy_cnt <= CNT_W'(WRITE_CYCLES);
            end else if (busy) begin
                busy_cnt <= busy_cnt - CNT_W'(1);
                if (commit_now) pmask <= '0;
            end
        end
    end

    // Storage array (nonvolatile model, not reset): masked page write at window end
    always_ff @(posedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (commit_now && pmask[i]) cells[{psel, ppage, 3'(i)}] <= pbuf[i];
        end
    end

    // R7: once started, the window counts down one per clock
    assert_window_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy_cnt == $past(busy_cnt) - CNT_W'(1)));

    // R8: a commit is only requested while no window is open
    assert_commit_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> !busy);

endmodule

// File: rtl/i2c_paged_nvm_slave.sv
// i2c_paged_nvm_slave: top level. Synchronizes the bus, runs the protocol
// engine and connects it to the paged two-bank store. SDA is open drain:
// sda_oe=1 pulls the line low. Assumes SCL phases of several clocks.
module i2c_paged_nvm_slave #(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic [7:0] main_cfg
);
    logic              sda_lv, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, mem_sel, wr_stb, page_set, commit_req;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wr_data, page_byte, rd_data;

    i2c_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lv(sda_lv), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_slave_fsm #(.PTR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lv(sda_lv), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .busy_i(busy), .addr_sel(addr_sel), .main_cfg(main_cfg),
        .rd_data(rd_data), .sda_oe(sda_oe), .mem_sel(mem_sel), .ptr(ptr),
        .wr_stb(wr_stb), .wr_data(wr_data), .page_set(page_set),
        .page_byte(page_byte), .commit_req(commit_req)
    );

    nvm_page_store #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .page_set(page_set), .set_sel(mem_sel),
        .set_addr(page_byte[ADDR_W-1:0]), .wr_stb(wr_stb), .wr_addr(ptr),
        .wr_data(wr_data), .commit_req(commit_req), .rd_sel(mem_sel),
        .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
    );

endmodule

// File: tb/test_i2c_paged_nvm_slave.sv
module test_i2c_paged_nvm_slave;
    localparam int WR_CYC = 1500;
    localparam int Q      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] main_cfg = 8'hA6;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_mem [512];
    logic       known   [512];
    logic [7:0] wbuf    [8];
    logic [7:0] rbuf    [8];

    always #2 clk = ~clk;

    i2c_paged_nvm_slave #(.ADDR_W(8), .WRITE_CYCLES(WR_CYC)) i_i2c_paged_nvm_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .main_cfg(main_cfg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(2 * Q);
            scl_m = 1'b0;
        end
        hold(Q / 2);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        ack = ~sda_line;
        hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic rbyte(input logic ack_m, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            scl_m = 1'b1; hold(Q);
            b[i] = sda_line;
            hold(Q);
            scl_m = 1'b0;
        end
        hold(Q / 2);
        sda_m = ~ack_m; hold(Q);
        scl_m = 1'b1; hold(2 * Q);
        scl_m = 1'b0; hold(Q / 2);
        sda_m = 1'b1;
    endtask

    // Address-only probe; returns the slave's answer
    task automatic probe(input logic [7:0] dev, output logic ack);
        bus_start();
        wbyte(dev, ack);
        bus_stop();
    endtask

    // Write n bytes from wbuf at pointer reg; returns number of NACKed bytes
    task automatic wr_seq(input logic [7:0] dev, input logic [7:0] rg, input int n, output int nacks);
        logic a;
        nacks = 0;
        bus_start();
        wbyte({dev[7:1], 1'b0}, a); if (!a) nacks++;
        wbyte(rg, a); if (!a) nacks++;
        for (int k = 0; k < n; k++) begin
            wbyte(wbuf[k], a); if (!a) nacks++;
        end
        bus_stop();
    endtask

    // Set pointer, repeated START, read n bytes into rbuf
    task automatic rd_seq(input logic [7:0] dev, input logic [7:0] rg, input int n, output int nacks);
        logic a;
        nacks = 0;
        bus_start();
        wbyte({dev[7:1], 1'b0}, a); if (!a) nacks++;
        wbyte(rg, a); if (!a) nacks++;
        bus_rstart();
        wbyte({dev[7:1], 1'b1}, a); if (!a) nacks++;
        for (int k = 0; k < n; k++) rbyte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic poll(input logic [7:0] dev, output int tries);
        logic a;
        tries = 0;
        do begin
            probe(dev, a);
            tries++;
        end while (!a && tries < 40);
    endtask

    // Reference: bytes land at {page, (start+k) mod 8}
    function automatic void model_write(input int sel, input logic [7:0] rg, input int n);
        for (int k = 0; k < n; k++) begin
            int idx = sel * 256 + {rg[7:3], 3'(rg[2:0] + 3'(k))};
            exp_mem[idx] = wbuf[k];
            known[idx]   = 1'b1;
        end
    endfunction

    // Reference: which bank (0 aux, 1 main, -1 none) an address byte reaches
    function automatic int bank_of(input logic [7:0] dev, input logic sel, input logic [7:0] cfg);
        logic [6:0] m = sel ? cfg[7:1] : 7'h51;
        if (dev[7:1] == m) return 1;
        if (dev[7:1] == 7'h50) return 0;
        return -1;
    endfunction

    task automatic check_page(input string req, input int sel, input logic [7:0] rg);
        int nk;
        logic [7:0] base = {rg[7:3], 3'b000};
        rd_seq(sel ? 8'hA2 : 8'hA0, base, 8, nk);
        chk({req, " read acks"}, nk, 0);
        for (int k = 0; k < 8; k++) begin
            int idx = sel * 256 + base + k;
            if (known[idx]) chk(req, rbuf[k], exp_mem[idx]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        int nk, tr, sel, len;
        logic [7:0] rg;
        void'($urandom(32'h5EED_1C2A));
        for (int i = 0; i < 512; i++) begin exp_mem[i] = 8'h00; known[i] = 1'b0; end
        hold(5);
        rst_n = 1'b1;
        hold(3);

        // R9: released after reset
        chk("R9 sda after reset", sda_oe, 0);

        // R1: fixed address map
        probe(8'hA0, a); chk("R1 aux A0", a, 1);
        probe(8'hA2, a); chk("R1 main A2", a, 1);
        probe(8'hA4, a); chk("R1 A4 foreign", a, 0);
        probe(8'hA6, a); chk("R1 A6 without select", a, 0);
        chk("R1 bank model", bank_of(8'hA6, 1'b0, main_cfg), -1);

        // R8: pointer-only write opens no window
        wr_seq(8'hA2, 8'h10, 0, nk); chk("R3 pointer-only acks", nk, 0);
        probe(8'hA2, a); chk("R8 probe after pointer-only", a, 1);

        // R3/R7/R6/R4: two-byte write at C8h, acknowledge polling, read back
        wbuf[0] = 8'h01; wbuf[1] = 8'h75;
        wr_seq(8'hA2, 8'hC8, 2, nk); chk("R3 write acks", nk, 0);
        model_write(1, 8'hC8, 2);
        probe(8'hA2, a); chk("R7 probe during window", a, 0);
        probe(8'hA0, a); chk("R7 aux probe during window", a, 0);
        poll(8'hA2, tr);
        chk("R7 polled ack reached", (tr > 1 && tr < 40) ? 1 : 0, 1);
        rd_seq(8'hA2, 8'hC8, 2, nk); chk("R4 read acks", nk, 0);
        chk("R4 byte C8", rbuf[0], 8'h01);
        chk("R4 byte C9", rbuf[1], 8'h75);
        probe(8'hA2, a); chk("R8 probe after read", a, 1);

        // R5/R6: fill page B8h, then a 4-byte burst from BEh wraps to B8h/B9h
        for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
        wr_seq(8'hA2, 8'hB8, 8, nk); chk("R3 full page acks", nk, 0);
        model_write(1, 8'hB8, 8); poll(8'hA2, tr);
        for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
        wr_seq(8'hA2, 8'hBE, 4, nk); chk("R3 wrap burst acks", nk, 0);
        model_write(1, 8'hBE, 4); poll(8'hA2, tr);
        check_page("R5 R6 wrapped page", 1, 8'hB8);

        // R10: aux write at C8h leaves main C8h
        wbuf[0] = 8'h3C;
        wr_seq(8'hA0, 8'hC8, 1, nk); model_write(0, 8'hC8, 1); poll(8'hA0, tr);
        rd_seq(8'hA2, 8'hC8, 1, nk); chk("R10 main untouched", rbuf[0], 8'h01);
        rd_seq(8'hA0, 8'hC8, 1, nk); chk("R10 aux written", rbuf[0], 8'h3C);

        // R2: programmed main address
        addr_sel = 1'b1; main_cfg = 8'hA6;
        probe(8'hA6, a); chk("R2 programmed main", a, 1);
        probe(8'hA2, a); chk("R2 old main refused", a, 0);
        probe(8'hA0, a); chk("R2 aux kept", a, 1);
        wbuf[0] = 8'h5A;
        wr_seq(8'hA6, 8'h40, 1, nk); model_write(1, 8'h40, 1); poll(8'hA6, tr);
        rd_seq(8'hA6, 8'h40, 1, nk); chk("R2 programmed read", rbuf[0], 8'h5A);

        // R2: clash at A0h, main wins
        main_cfg = 8'hA0;
        wbuf[0] = 8'h99;
        wr_seq(8'hA0, 8'hC8, 1, nk); model_write(1, 8'hC8, 1); poll(8'hA0, tr);
        addr_sel = 1'b0;
        rd_seq(8'hA2, 8'hC8, 1, nk); chk("R2 clash went to main", rbuf[0], 8'h99);
        rd_seq(8'hA0, 8'hC8, 1, nk); chk("R2 clash aux kept", rbuf[0], 8'h3C);

        // Random bursts (R3 R5 R6 R7) checked against the page model
        for (int it = 0; it < 10; it++) begin
            sel = int'($urandom_range(1, 0));
            rg  = 8'($urandom);
            len = int'($urandom_range(8, 1));
            for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
            wr_seq(sel ? 8'hA2 : 8'hA0, rg, len, nk);
            chk("R3 random write acks", nk, 0);
            model_write(sel, rg, len);
            probe(sel ? 8'hA2 : 8'hA0, a);
            chk("R7 random probe refused", a, 0);
            poll(sel ? 8'hA2 : 8'hA0, tr);
            check_page("R6 random page", sel, rg);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule